// File: doc/BRIEF.md
# Network Controller Configuration Header Registers

This block holds a slice of the configuration header that a network controller presents on a PCI-style bus. It covers the revision byte, the three-byte class code, the cache line size byte, the latency timer byte and the header type byte. A host reaches them through a small dword-addressed port with per-byte write enables. Reads are combinational and return the whole addressed dword.

Two identity fields can be tuned by a non-volatile loader. After reset, the loader pulses a one-cycle strobe carrying a replacement for the low revision bits and a header type byte. From then on those values replace the built-in defaults.

The cache line size byte only keeps one of two legal sizes, eight or sixteen dwords. Any other write clears it. A flag derived from it tells the bus master whether the write-and-invalidate command may be issued. The latency timer byte is passed straight to the bus master as its ownership budget in bus clocks.

Top module: `cfg_hdr_regs`

## Requirements
- R1: While reset is asserted and right after it is released, dword 2 reads 0x0200000F, dword 3 reads 0x00000000, `mwi_en` is 0 and `lat_timer` is 0x00.
- R2: Dword 2 is read-only. Byte 0 is the revision and bytes 1..3 are the class code 0x00 (interface), 0x00 (subclass), 0x02 (base class). Writes to dword 2 change nothing.
- R3: On a clock edge with `ee_load` high, the revision bits [2:0] become `ee_rev_low` if `ee_rev_ovr_en` is 1, or their default 3'b111 if it is 0. Bits [7:3] always read 5'b00001.
- R4: The header type is byte 2 of dword 3. It resets to 0x00 and takes `ee_hdr_type` on a clock edge with `ee_load` high. Host writes to it are ignored. Byte 3 of dword 3 always reads 0x00.
- R5: A write to byte 0 of dword 3 with the value exactly 0x08 makes that byte read 0x08 and sets `mwi_en` to 1.
- R6: A write to byte 0 of dword 3 with the value exactly 0x10 makes that byte read 0x10 and sets `mwi_en` to 1.
- R7: A write of any other value to byte 0 of dword 3 makes that byte read 0x00 and clears `mwi_en`, even when a legal size was held before.
- R8: A write to byte 1 of dword 3 stores the byte. The byte is readable there and driven on `lat_timer`.
- R9: A write changes only the bytes whose `cfg_be` bit is 1; bit i enables byte i of `cfg_wdata`. With `cfg_be[0]` low, the cache line size byte and `mwi_en` keep their values whatever byte 0 of the data holds.
- R10: Every dword address other than 2 and 3 reads 0x00000000.
- R11: Writes and loads take effect on the clock edge where they are sampled. `cfg_rdata` follows `cfg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | 6 | Dword address within the header |
| cfg_we | input | 1 | Write request for the addressed dword |
| cfg_be | input | 4 | Byte write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed dword |
| ee_load | input | 1 | One-cycle strobe from the loader |
| ee_rev_ovr_en | input | 1 | Replace the low revision bits on load |
| ee_rev_low | input | 3 | Replacement low revision bits |
| ee_hdr_type | input | 8 | Header type value from the loader |
| mwi_en | output | 1 | Write-and-invalidate permitted |
| lat_timer | output | 8 | Bus ownership budget in clocks |

## Verification
The cache line size filter is driven with the two legal values and with near misses. The near misses are 0x18, which contains the bit pattern of 0x08, and 0x09, 0x80, 0x20 and 0x00. This separates an exact compare from a bit-mask test or a range test. Legal and illegal values are written in alternation, which shows that a bad write clears a held size instead of being dropped. Byte-enable patterns that put legal sizes in disabled lanes show that the enables gate the write rather than just the data. Loader strobes with the override on and off, and host writes aimed at the identity bytes, separate the loaded fields from the fixed ones.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
   localparam int BYTE_W  = 8;
   localparam int DWORD_W = 32;
   localparam int LANES   = DWORD_W / BYTE_W;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [1:0] {
      CLS_NONE  = 2'd0,
      CLS_SMALL = 2'd1,
      CLS_LARGE = 2'd2
   } cls_sel_e;
endpackage

// File: rtl/cfg_byte_reg.sv
module cfg_byte_reg
   import cfg_hdr_pkg::*;
#(
   parameter byte_t RESET_VAL = '0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  byte_t wr_byte,
   output byte_t value
);
   byte_t q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RESET_VAL;
      else if (wr_en) q <= wr_byte;
   end

   assign value = q;
endmodule

// File: rtl/cfg_cls_reg.sv
module cfg_cls_reg
   import cfg_hdr_pkg::*;
#(
   parameter byte_t SIZE_SMALL = 8'h08,
   parameter byte_t SIZE_LARGE = 8'h10,
   parameter bit    ENCODED    = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  byte_t wr_byte,
   output byte_t cls_byte,
   output logic  mwi_en
);
   if (SIZE_SMALL == SIZE_LARGE) begin : g_bad_sizes
      $error("cfg_cls_reg: the two legal sizes must differ");
   end
   if (SIZE_SMALL == '0 || SIZE_LARGE == '0) begin : g_bad_zero
      $error("cfg_cls_reg: zero cannot be a legal size");
   end

   if (ENCODED) begin : g_enc
      cls_sel_e sel_q;
      cls_sel_e sel_d;

      always_comb begin
         if (wr_byte == SIZE_SMALL)      sel_d = CLS_SMALL;
         else if (wr_byte == SIZE_LARGE) sel_d = CLS_LARGE;
         else                            sel_d = CLS_NONE;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     sel_q <= CLS_NONE;
         else if (wr_en) sel_q <= sel_d;
      end

      always_comb begin
         unique case (sel_q)
            CLS_SMALL: cls_byte = SIZE_SMALL;
            CLS_LARGE: cls_byte = SIZE_LARGE;
            default:   cls_byte = '0;
         endcase
      end
      assign mwi_en = (sel_q != CLS_NONE);
   end else begin : g_raw
      byte_t q;
      logic  legal;

      assign legal = (wr_byte == SIZE_SMALL) || (wr_byte == SIZE_LARGE);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= '0;
         else if (wr_en) q <= legal ? wr_byte : '0;
      end

      assign cls_byte = q;
      assign mwi_en   = (q != '0);
   end
endmodule

// File: rtl/cfg_ident_regs.sv
module cfg_ident_regs
   import cfg_hdr_pkg::*;
#(
   parameter byte_t REV_DEFAULT  = 8'h0F,
   parameter int    REV_OVR_BITS = 3,
   parameter byte_t HDR_DEFAULT  = 8'h00,
   localparam int   OVR_W        = (REV_OVR_BITS == 0) ? 1 : REV_OVR_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ee_load,
   input  logic             ee_rev_ovr_en,
   input  logic [OVR_W-1:0] ee_rev_low,
   input  byte_t            ee_hdr_type,
   output byte_t            rev_id,
   output byte_t            hdr_type
);
   if (REV_OVR_BITS < 0 || REV_OVR_BITS > BYTE_W) begin : g_bad_ovr
      $error("cfg_ident_regs: REV_OVR_BITS out of range");
   end

   if (REV_OVR_BITS == 0) begin : g_fixed
      assign rev_id = REV_DEFAULT;
   end else begin : g_ovr
      logic [REV_OVR_BITS-1:0] low_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            low_q <= REV_DEFAULT[REV_OVR_BITS-1:0];
         else if (ee_load)
            low_q <= ee_rev_ovr_en ? ee_rev_low : REV_DEFAULT[REV_OVR_BITS-1:0];
      end

      if (REV_OVR_BITS == BYTE_W) begin : g_full
         assign rev_id = low_q;
      end else begin : g_part
         assign rev_id = {REV_DEFAULT[BYTE_W-1:REV_OVR_BITS], low_q};
      end
   end

   cfg_byte_reg #(.RESET_VAL(HDR_DEFAULT)) u_hdr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ee_load),
      .wr_byte (ee_hdr_type),
      .value   (hdr_type)
   );
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
   import cfg_hdr_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int ID_DWORD   = 2,
   parameter int MISC_DWORD = 3
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DWORD_W-1:0] id_word,
   input  logic [DWORD_W-1:0] misc_word,
   output logic [DWORD_W-1:0] rdata
);
   always_comb begin
      if (addr == ADDR_W'(ID_DWORD))        rdata = id_word;
      else if (addr == ADDR_W'(MISC_DWORD)) rdata = misc_word;
      else                                  rdata = '0;
   end
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
   import cfg_hdr_pkg::*;
#(
   parameter int    ADDR_W       = 6,
   parameter int    ID_DWORD     = 2,
   parameter int    MISC_DWORD   = 3,
   parameter byte_t REV_DEFAULT  = 8'h0F,
   parameter int    REV_OVR_BITS = 3,
   parameter byte_t BASE_CLASS   = 8'h02,
   parameter byte_t SUB_CLASS    = 8'h00,
   parameter byte_t PROG_IF      = 8'h00,
   parameter byte_t HDR_DEFAULT  = 8'h00,
   parameter byte_t CLS_SMALL_SZ = 8'h08,
   parameter byte_t CLS_LARGE_SZ = 8'h10,
   parameter bit    CLS_ENCODED  = 1'b1,
   localparam int   OVR_W        = (REV_OVR_BITS == 0) ? 1 : REV_OVR_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic                cfg_we,
   input  logic [LANES-1:0]    cfg_be,
   input  logic [DWORD_W-1:0]  cfg_wdata,
   output logic [DWORD_W-1:0]  cfg_rdata,
   input  logic                ee_load,
   input  logic                ee_rev_ovr_en,
   input  logic [OVR_W-1:0]    ee_rev_low,
   input  logic [BYTE_W-1:0]   ee_hdr_type,
   output logic                mwi_en,
   output logic [BYTE_W-1:0]   lat_timer
);
   if (ID_DWORD == MISC_DWORD) begin : g_bad_map
      $error("cfg_hdr_regs: header dwords overlap");
   end
   if ((ID_DWORD >> ADDR_W) != 0 || (MISC_DWORD >> ADDR_W) != 0) begin : g_bad_addr
      $error("cfg_hdr_regs: ADDR_W too narrow for the map");
   end

   logic  misc_wr;
   byte_t wr_lane [LANES];
   logic  lane_we [LANES];
   byte_t rev_id, hdr_type, cls_byte;

   assign misc_wr = cfg_we && (cfg_addr == ADDR_W'(MISC_DWORD));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign wr_lane[i] = cfg_wdata[i*BYTE_W +: BYTE_W];
      assign lane_we[i] = misc_wr && cfg_be[i];
   end

   cfg_ident_regs #(
      .REV_DEFAULT  (REV_DEFAULT),
      .REV_OVR_BITS (REV_OVR_BITS),
      .HDR_DEFAULT  (HDR_DEFAULT)
   ) u_ident (
      .clk           (clk),
      .rst_n         (rst_n),
      .ee_load       (ee_load),
      .ee_rev_ovr_en (ee_rev_ovr_en),
      .ee_rev_low    (ee_rev_low),
      .ee_hdr_type   (ee_hdr_type),
      .rev_id        (rev_id),
      .hdr_type      (hdr_type)
   );

   cfg_cls_reg #(
      .SIZE_SMALL (CLS_SMALL_SZ),
      .SIZE_LARGE (CLS_LARGE_SZ),
      .ENCODED    (CLS_ENCODED)
   ) u_cls (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (lane_we[0]),
      .wr_byte  (wr_lane[0]),
      .cls_byte (cls_byte),
      .mwi_en   (mwi_en)
   );

   cfg_byte_reg #(.RESET_VAL(8'h00)) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lane_we[1]),
      .wr_byte (wr_lane[1]),
      .value   (lat_timer)
   );

   cfg_rd_mux #(
      .ADDR_W     (ADDR_W),
      .ID_DWORD   (ID_DWORD),
      .MISC_DWORD (MISC_DWORD)
   ) u_rd (
      .addr      (cfg_addr),
      .id_word   ({BASE_CLASS, SUB_CLASS, PROG_IF, rev_id}),
      .misc_word ({8'h00, hdr_type, lat_timer, cls_byte}),
      .rdata     (cfg_rdata)
   );
endmodule

// File: rtl/cfg_hdr_regs_chk.sv
module cfg_hdr_regs_chk #(
   parameter int       ADDR_W     = 6,
   parameter int       ID_DWORD   = 2,
   parameter int       MISC_DWORD = 3,
   parameter bit [7:0] SZ_A       = 8'h08,
   parameter bit [7:0] SZ_B       = 8'h10,
   parameter bit [7:0] BASE_C     = 8'h02,
   parameter bit [7:0] SUB_C      = 8'h00,
   parameter bit [7:0] PIF_C      = 8'h00
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic              cfg_we,
   input logic [3:0]        cfg_be,
   input logic [31:0]       cfg_wdata,
   input logic [31:0]       cfg_rdata,
   input logic              ee_load,
   input logic              mwi_en,
   input logic [7:0]        lat_timer
);
   logic lane0_wr, lane1_wr, at_misc, at_id;
   assign at_misc  = (cfg_addr == ADDR_W'(MISC_DWORD));
   assign at_id    = (cfg_addr == ADDR_W'(ID_DWORD));
   assign lane0_wr = cfg_we && at_misc && cfg_be[0];
   assign lane1_wr = cfg_we && at_misc && cfg_be[1];

   // R5
   cls_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane0_wr && (cfg_wdata[7:0] == SZ_A || cfg_wdata[7:0] == SZ_B) |=> mwi_en);

   // R7
   cls_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane0_wr && cfg_wdata[7:0] != SZ_A && cfg_wdata[7:0] != SZ_B |=> !mwi_en);

   // R9
   mwi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane0_wr |=> $stable(mwi_en));

   // R8
   lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane1_wr |=> lat_timer == $past(cfg_wdata[15:8]));

   // R9
   lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane1_wr |=> $stable(lat_timer));

   // R2
   class_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_id |-> cfg_rdata[31:8] == {BASE_C, SUB_C, PIF_C});

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !at_id && !at_misc |-> cfg_rdata == 32'h0);

   // R4
   hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_misc && $past(at_misc) && !$past(ee_load) |-> cfg_rdata[23:16] == $past(cfg_rdata[23:16]));
endmodule

bind cfg_hdr_regs cfg_hdr_regs_chk #(
   .ADDR_W     (ADDR_W),
   .ID_DWORD   (ID_DWORD),
   .MISC_DWORD (MISC_DWORD),
   .SZ_A       (CLS_SMALL_SZ),
   .SZ_B       (CLS_LARGE_SZ),
   .BASE_C     (BASE_CLASS),
   .SUB_C      (SUB_CLASS),
   .PIF_C      (PROG_IF)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_addr  (cfg_addr),
   .cfg_we    (cfg_we),
   .cfg_be    (cfg_be),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .ee_load   (ee_load),
   .mwi_en    (mwi_en),
   .lat_timer (lat_timer)
);

// File: tb/cfg_hdr_regs_bench.sv
module cfg_hdr_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_addr = 6'd2;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_be = 4'h0;
   logic [31:0] cfg_wdata = 32'h0;
   logic [31:0] cfg_rdata;
   logic        ee_load = 1'b0;
   logic        ee_rev_ovr_en = 1'b0;
   logic [2:0]  ee_rev_low = 3'b000;
   logic [7:0]  ee_hdr_type = 8'h00;
   logic        mwi_en;
   logic [7:0]  lat_timer;

   always #2 clk = ~clk;

   cfg_hdr_regs u_cfg_hdr_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_addr      (cfg_addr),
      .cfg_we        (cfg_we),
      .cfg_be        (cfg_be),
      .cfg_wdata     (cfg_wdata),
      .cfg_rdata     (cfg_rdata),
      .ee_load       (ee_load),
      .ee_rev_ovr_en (ee_rev_ovr_en),
      .ee_rev_low    (ee_rev_low),
      .ee_hdr_type   (ee_hdr_type),
      .mwi_en        (mwi_en),
      .lat_timer     (lat_timer)
   );

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   string cur_req = "R1";

   // reference model state
   int m_cls = 0, m_lat = 0, m_hdr = 0, m_revlo = 7;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cls = 0; m_lat = 0; m_hdr = 0; m_revlo = 7;
      end else begin
         if (ee_load) begin
            m_revlo = ee_rev_ovr_en ? int'(ee_rev_low) : 7;
            m_hdr   = int'(ee_hdr_type);
         end
         if (cfg_we && cfg_addr == 6'd3) begin
            if (cfg_be[0]) begin
               if (cfg_wdata[7:0] == 8'd8 || cfg_wdata[7:0] == 8'd16) m_cls = int'(cfg_wdata[7:0]);
               else m_cls = 0;
            end
            if (cfg_be[1]) m_lat = int'(cfg_wdata[15:8]);
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      if (a == 6'd2) return {8'h02, 8'h00, 8'h00, 5'b00001, 3'(m_revlo)};
      if (a == 6'd3) return {8'h00, 8'(m_hdr), 8'(m_lat), 8'(m_cls)};
      return 32'h0;
   endfunction

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%08h expected=%08h", cur_req, what, act, exp);
      end
   endtask

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         check("rdata", cfg_rdata, exp_rd(cfg_addr));
         check("mwi_en", {31'h0, mwi_en}, {31'h0, (m_cls != 0)});
         check("lat_timer", {24'h0, lat_timer}, 32'(m_lat));
      end
   end

   task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_addr = a; cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0; cfg_be = 4'h0; cfg_addr = 6'd3;
   endtask

   task automatic rd(input logic [5:0] a);
      @(posedge clk); #1;
      cfg_addr = a; cfg_we = 1'b0;
   endtask

   task automatic load(input logic ovr, input logic [2:0] lo, input logic [7:0] hdr);
      @(posedge clk); #1;
      ee_load = 1'b1; ee_rev_ovr_en = ovr; ee_rev_low = lo; ee_hdr_type = hdr;
      @(posedge clk); #1;
      ee_load = 1'b0; ee_hdr_type = 8'h5A; ee_rev_low = 3'b101;
   endtask

   task automatic finish_up;
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_up();
      end
   end

   initial begin
      // R1: reset values, held and just after release
      cur_req = "R1";
      rd(6'd2); rd(6'd3);
      @(posedge clk); #1 rst_n = 1'b1;
      rd(6'd2); rd(6'd3);
      // R10: unmapped dwords
      cur_req = "R10";
      rd(6'd0); rd(6'd1); rd(6'd4); rd(6'd63);
      // R2: identity dword is read-only
      cur_req = "R2";
      wr(6'd2, 4'hF, 32'hFFFF_FFFF); rd(6'd2);
      wr(6'd2, 4'h1, 32'h0000_0008); rd(6'd2);
      // R3 / R4: loader strobes
      cur_req = "R3";
      load(1'b1, 3'b010, 8'h80); rd(6'd2); rd(6'd3);
      load(1'b0, 3'b000, 8'h00); rd(6'd2);
      load(1'b1, 3'b000, 8'h80); rd(6'd2);
      cur_req = "R4";
      wr(6'd3, 4'h4, 32'h00FF_0000); rd(6'd3);
      wr(6'd3, 4'h8, 32'hFF00_0000); rd(6'd3);
      // R5 / R6 / R7: cache line size filter
      cur_req = "R5";
      wr(6'd3, 4'h1, 32'h0000_0008); rd(6'd3);
      cur_req = "R7";
      wr(6'd3, 4'h1, 32'h0000_0018); rd(6'd3);
      cur_req = "R6";
      wr(6'd3, 4'h1, 32'h0000_0010); rd(6'd3);
      cur_req = "R7";
      wr(6'd3, 4'h1, 32'h0000_0009);
      wr(6'd3, 4'h1, 32'h0000_0008);
      wr(6'd3, 4'h1, 32'h0000_0080);
      wr(6'd3, 4'h1, 32'h0000_0010);
      wr(6'd3, 4'h1, 32'h0000_0020);
      wr(6'd3, 4'h1, 32'h0000_0010);
      wr(6'd3, 4'h1, 32'h0000_0000); rd(6'd3);
      // R8: latency timer
      cur_req = "R8";
      wr(6'd3, 4'h2, 32'h0000_AB00); rd(6'd3);
      wr(6'd3, 4'h2, 32'h0000_FF00); rd(6'd3);
      // R9: byte enables gate the write
      cur_req = "R9";
      wr(6'd3, 4'h2, 32'h0000_3308); rd(6'd3);
      wr(6'd3, 4'h1, 32'h0000_EE10); rd(6'd3);
      wr(6'd3, 4'hC, 32'h1111_0008); rd(6'd3);
      wr(6'd3, 4'hF, 32'hFFFF_5508); rd(6'd3);
      // R11: back-to-back writes, each visible the next cycle
      cur_req = "R11";
      @(posedge clk); #1;
      cfg_addr = 6'd3; cfg_we = 1'b1; cfg_be = 4'h3; cfg_wdata = 32'h0000_1210;
      @(posedge clk); #1;
      cfg_wdata = 32'h0000_3407;
      @(posedge clk); #1;
      cfg_wdata = 32'h0000_5608;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      rd(6'd2); rd(6'd3);
      repeat (2) @(posedge clk);
      finish_up();
   end
endmodule